// File: doc/BRIEF.md
# Configurable Port Input Debouncer

This block filters contact bounce and line glitches on a small group of port inputs. Each input first passes through a two-flop synchronizer. A per-pin state machine then decides when the filtered output may take a new level. All pins share one 15-bit timer, which counts on one of two tick enables: a slow tick for key-style inputs or a fast tick for serial-line inputs. A debounce period ends when one selected byte of the timer equals an 8-bit compare value. The low byte gives short periods and the high byte (bits 14:7) gives long ones.

Two filtering modes are offered. In stable mode a pin's output takes a new level only after the raw level has held still for a full period. In fast mode the output follows the first edge at once, and further activity is ignored until the period ends. Every committed change raises an event on a valid/ready output. Until that event is accepted, the whole debouncer is frozen: no pin changes state and the timer holds.

Software reaches the block through a plain register port. This port carries an 8-bit configuration register, an 8-bit compare register and a per-pin enable mask. The configuration and compare registers accept writes only while every enable is clear.

Top module: `port_debouncer`

## Requirements
- R1: After reset `cfg_rdata` reads 0x00, `evt_valid` is 0 and `pin_deb` is all zeros.
- R2: Configuration bit 0 selects the mode (0 stable, 1 fast), bit 1 the tick (0 `tick_slow`, 1 `tick_fast`) and bit 2 the compare window. Bit 3 reads the handshake-active flag and ignores writes. Bits 7:4 read 0 and ignore writes.
- R3: A write to the configuration or compare register is ignored while any bit of the enable mask is 1.
- R4: In stable mode an enabled pin's `pin_deb` takes the synchronized raw level only after that level has been unchanged for one full period. Any change during the period restarts the timer, and a pin that returns to its old level raises no event.
- R5: In fast mode an enabled pin's `pin_deb` follows a raw edge within 3 clock edges of the input change. Changes during the following period are ignored. When the period ends the raw level is sampled again.
- R6: With bit 1 at 0 the timer advances only on `tick_slow`; with bit 1 at 1 it advances only on `tick_fast`.
- R7: With bit 2 at 0 the compare value is matched against timer bits 14:7. With bit 2 at 1 it is matched against timer bits 7:0.
- R8: Each commit of a new output level raises `evt_valid`, with `evt_pins` marking the pins that changed. Both hold steady until a cycle in which `evt_valid` and `evt_ready` are both 1. `cfg_rdata[3]` equals `evt_valid`.
- R9: While an event is pending, no enabled pin's `pin_deb` changes and the timer holds its value.
- R10: A disabled pin's `pin_deb` follows its synchronized raw input and never raises an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_slow | input | 1 | Slow timer tick enable |
| tick_fast | input | 1 | Fast timer tick enable |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration readback, handshake flag in bit 3 |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | CMP_W | Compare value |
| en_we | input | 1 | Enable mask write strobe |
| en_wdata | input | NPINS | Per-pin enable mask |
| pin_raw | input | NPINS | Raw asynchronous pin levels |
| pin_deb | output | NPINS | Debounced pin levels |
| evt_valid | output | 1 | Event pending |
| evt_ready | input | 1 | Event accepted when high together with `evt_valid` |
| evt_pins | output | NPINS | Pins whose level changed in the pending event |

## Verification
The assertions assume `evt_ready` may be held low for any length of time. Back-pressure only freezes the block; it never loses an event. The freeze check on the debounced outputs also assumes the enable mask is not rewritten in the same cycle. The stimulus changes configuration only by first clearing every enable, and always drives the raw pins at the falling edge. The compare value is never set to zero, so that every period the bench times begins from a cleared timer.

// File: rtl/pdeb_pkg.sv
package pdeb_pkg;
  typedef struct packed {
    logic win_lo;     // bit 2
    logic tick_fast;  // bit 1
    logic fast_mode;  // bit 0
  } pdeb_cfg_t;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_ARMED = 2'd1,
    PS_HOLD  = 2'd2
  } pdeb_state_t;
endpackage

// File: rtl/pdeb_sync.sv
module pdeb_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pdeb_timer.sv
module pdeb_timer #(
  parameter int TMR_W = 15,
  parameter int CMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_slow,
  input  logic             tick_fast,
  input  logic             sel_fast,
  input  logic             win_lo,
  input  logic [CMP_W-1:0] cmp,
  input  logic             restart,
  input  logic             hold,
  output logic             match
);
  localparam int HI_LSB = TMR_W - CMP_W;

  logic [TMR_W-1:0] cnt_q;
  logic             tick;
  logic [CMP_W-1:0] win_val;

  assign tick    = sel_fast ? tick_fast : tick_slow;
  assign win_val = win_lo ? cnt_q[CMP_W-1:0] : cnt_q[TMR_W-1:HI_LSB];
  assign match   = (win_val == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (!hold && tick) cnt_q <= cnt_q + 1'b1;
  end

  AST_TIMER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !restart) |=> (cnt_q == $past(cnt_q)))
    else $error("timer moved while frozen"); // R9

  AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0))
    else $error("timer not cleared on restart"); // R4
endmodule

// File: rtl/pdeb_pin.sv
module pdeb_pin
  import pdeb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fast_mode,
  input  logic freeze,
  input  logic din,
  input  logic match,
  output logic deb,
  output logic restart_req,
  output logic commit
);
  pdeb_state_t state_q, state_d;
  logic        din_prev_q;
  logic        deb_d;

  always_comb begin
    state_d     = state_q;
    deb_d       = deb;
    restart_req = 1'b0;
    commit      = 1'b0;
    if (en && !freeze) begin
      unique case (state_q)
        PS_IDLE: if (din != deb) begin
          restart_req = 1'b1;
          if (fast_mode) begin
            commit  = 1'b1;
            deb_d   = din;
            state_d = PS_HOLD;
          end else begin
            state_d = PS_ARMED;
          end
        end
        PS_ARMED: if (din != din_prev_q) begin
          restart_req = 1'b1;
        end else if (match) begin
          state_d = PS_IDLE;
          if (din != deb) begin
            commit = 1'b1;
            deb_d  = din;
          end
        end
        PS_HOLD: if (match) state_d = PS_IDLE;
        default: state_d = PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PS_IDLE;
      deb        <= 1'b0;
      din_prev_q <= 1'b0;
    end else begin
      din_prev_q <= din;
      if (!en) begin
        state_q <= PS_IDLE;
        deb     <= din;
      end else begin
        state_q <= state_d;
        deb     <= deb_d;
      end
    end
  end

  AST_STABLE_NEEDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !fast_mode && commit) |-> (din == din_prev_q))
    else $error("stable commit on a moving input"); // R4
endmodule

// File: rtl/port_debouncer.sv
module port_debouncer
  import pdeb_pkg::*;
#(
  parameter int NPINS = 4,
  parameter int TMR_W = 15,
  parameter int CMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_slow,
  input  logic             tick_fast,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  input  logic             cmp_we,
  input  logic [CMP_W-1:0] cmp_wdata,
  input  logic             en_we,
  input  logic [NPINS-1:0] en_wdata,
  input  logic [NPINS-1:0] pin_raw,
  output logic [NPINS-1:0] pin_deb,
  output logic             evt_valid,
  input  logic             evt_ready,
  output logic [NPINS-1:0] evt_pins
);
  localparam int CFG_BITS = $bits(pdeb_cfg_t);

  pdeb_cfg_t        cfg_q;
  logic [CMP_W-1:0] cmp_q;
  logic [NPINS-1:0] en_q;
  logic [NPINS-1:0] din;
  logic [NPINS-1:0] restart_v;
  logic [NPINS-1:0] commit_v;
  logic             match;
  logic             hs_q;
  logic             unlocked;

  assign unlocked = ~|en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cmp_q <= '0;
      en_q  <= '0;
    end else begin
      if (cfg_we && unlocked) cfg_q <= pdeb_cfg_t'(cfg_wdata[CFG_BITS-1:0]);
      if (cmp_we && unlocked) cmp_q <= cmp_wdata;
      if (en_we)              en_q  <= en_wdata;
    end
  end

  assign cfg_rdata = {4'b0000, hs_q, cfg_q};

  pdeb_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(din)
  );

  pdeb_timer #(.TMR_W(TMR_W), .CMP_W(CMP_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .tick_slow(tick_slow), .tick_fast(tick_fast),
    .sel_fast(cfg_q.tick_fast), .win_lo(cfg_q.win_lo),
    .cmp(cmp_q), .restart(|restart_v), .hold(hs_q), .match(match)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    pdeb_pin u_pin (
      .clk(clk), .rst_n(rst_n), .en(en_q[i]),
      .fast_mode(cfg_q.fast_mode), .freeze(hs_q),
      .din(din[i]), .match(match), .deb(pin_deb[i]),
      .restart_req(restart_v[i]), .commit(commit_v[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q     <= 1'b0;
      evt_pins <= '0;
    end else if (|commit_v) begin
      hs_q     <= 1'b1;
      evt_pins <= commit_v;
    end else if (hs_q && evt_ready) begin
      hs_q <= 1'b0;
    end
  end

  assign evt_valid = hs_q;

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_we || cmp_we) && !unlocked) |=> ($stable(cfg_q) && $stable(cmp_q)))
    else $error("config changed while enabled"); // R3

  AST_EVT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_pins)))
    else $error("event dropped without acceptance"); // R8

  AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready && !en_we) |=> $stable(pin_deb & en_q))
    else $error("output moved while event pending"); // R9

  AST_NO_COMMIT_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (commit_v == '0))
    else $error("commit during pending event"); // R9
endmodule

// File: tb/port_debouncer_bench.sv
module port_debouncer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_slow = 1'b0;
  logic          tick_fast = 1'b1;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_wdata = '0;
  logic [7:0]    cfg_rdata;
  logic          cmp_we = 1'b0;
  logic [7:0]    cmp_wdata = '0;
  logic          en_we = 1'b0;
  logic [NP-1:0] en_wdata = '0;
  logic [NP-1:0] pin_raw = '0;
  logic [NP-1:0] pin_deb;
  logic          evt_valid;
  logic          evt_ready = 1'b0;
  logic [NP-1:0] evt_pins;

  int n_checks = 0;
  int n_fail = 0;
  int slow_div = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    slow_div  <= (slow_div == 3) ? 0 : slow_div + 1;
    tick_slow <= (slow_div == 3);
  end

  port_debouncer u_port_debouncer (
    .clk(clk), .rst_n(rst_n), .tick_slow(tick_slow), .tick_fast(tick_fast),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .en_we(en_we), .en_wdata(en_wdata),
    .pin_raw(pin_raw), .pin_deb(pin_deb), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .evt_pins(evt_pins)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic configure(input logic [7:0] c, input logic [7:0] cmpv, input logic [NP-1:0] en);
    @(negedge clk); en_we = 1'b1; en_wdata = '0;
    @(negedge clk); en_we = 1'b0; cfg_we = 1'b1; cfg_wdata = c; cmp_we = 1'b1; cmp_wdata = cmpv;
    @(negedge clk); cfg_we = 1'b0; cmp_we = 1'b0; en_we = 1'b1; en_wdata = en;
    @(negedge clk); en_we = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); evt_ready = 1'b1;
    @(negedge clk); evt_ready = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 cfg_rdata", cfg_rdata, 8'h00);
    check("R1 evt_valid", evt_valid, 0);
    check("R1 pin_deb", pin_deb, 0);
  endtask

  task automatic t_reserved();
    configure(8'hF9, 8'd20, '0);
    check("R2 reserved and flag bits", cfg_rdata, 8'h01);
  endtask

  task automatic t_lock();
    configure(8'h00, 8'd20, 4'b0001);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = 8'h07;
    @(negedge clk); cfg_we = 1'b0;
    check("R3 write refused", cfg_rdata, 8'h00);
  endtask

  task automatic t_stable();
    configure(8'h06, 8'd20, 4'b0111);
    pin_raw[0] = 1'b1;
    cyc(12); check("R4 not yet", pin_deb[0], 0);
    cyc(28); check("R4 settled", pin_deb[0], 1);
    check("R8 evt_valid", evt_valid, 1);
    check("R8 evt_pins", evt_pins, 4'b0001);
    check("R8 flag bit3", cfg_rdata[3], 1);
    ack(); check("R8 accepted", evt_valid, 0);
    // bounce: each pulse shorter than the period
    pin_raw[0] = 1'b0; cyc(8); pin_raw[0] = 1'b1; cyc(8);
    pin_raw[0] = 1'b0; cyc(8); pin_raw[0] = 1'b1; cyc(8);
    pin_raw[0] = 1'b0; cyc(8);
    check("R4 bounce held", pin_deb[0], 1);
    check("R4 no event during bounce", evt_valid, 0);
    cyc(40); check("R4 after bounce", pin_deb[0], 0);
    ack();
    // glitch that returns to old level: no event
    pin_raw[0] = 1'b1; cyc(6); pin_raw[0] = 1'b0; cyc(50);
    check("R4 glitch no event", evt_valid, 0);
    check("R4 glitch level", pin_deb[0], 0);
  endtask

  task automatic t_stall();
    pin_raw[1] = 1'b1; cyc(40);
    check("R8 pin1 event", evt_pins, 4'b0010);
    pin_raw[1] = 1'b0; cyc(60);
    check("R9 frozen output", pin_deb[1], 1);
    check("R9 still pending", evt_valid, 1);
    ack(); cyc(40);
    check("R9 resumed", pin_deb[1], 0);
    check("R9 new event", evt_valid, 1);
    ack();
  endtask

  task automatic t_disabled();
    pin_raw[3] = 1'b1; cyc(5);
    check("R10 passthrough", pin_deb[3], 1);
    check("R10 no event", evt_valid, 0);
  endtask

  task automatic t_slow();
    configure(8'h04, 8'd20, 4'b0001);
    pin_raw[0] = 1'b1; cyc(40);
    check("R6 slow not yet", pin_deb[0], 0);
    cyc(90); check("R6 slow settled", pin_deb[0], 1);
    ack();
  endtask

  task automatic t_window_hi();
    configure(8'h02, 8'd1, 4'b0001);
    pin_raw[0] = 1'b0; cyc(60);
    check("R7 high window not yet", pin_deb[0], 1);
    cyc(120); check("R7 high window settled", pin_deb[0], 0);
    ack();
  endtask

  task automatic t_fast();
    configure(8'h07, 8'd20, 4'b0001);
    pin_raw[0] = 1'b1; cyc(4);
    check("R5 immediate", pin_deb[0], 1);
    check("R5 event", evt_valid, 1);
    pin_raw[0] = 1'b0; cyc(2); ack(); cyc(5);
    check("R5 hold ignores", pin_deb[0], 1);
    cyc(40);
    check("R5 resampled", pin_deb[0], 0);
    check("R5 second event", evt_valid, 1);
    ack();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1'b1; cyc(1);
    t_reset();
    t_reserved();
    t_lock();
    t_stable();
    t_stall();
    t_disabled();
    t_slow();
    t_window_hi();
    t_fast();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule